// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a physical frame to evict using the clock (second-chance) policy. It keeps one referenced bit for each of `N_FRAMES` frames. A frame's bit is set whenever an access strobe names that frame. Accesses never reorder anything; they only set the bit.

When the host asks for a victim, a sweep starts at a persistent hand pointer. It moves through the frames in a fixed circular order, one frame per cycle. Each frame it passes with the bit set gets its bit cleared and is skipped. The first frame found with a clear bit becomes the victim. The hand then parks on the frame after the victim, so the next search resumes there.

The block is meant to sit beside a page-table walker or a fault handler, which owns the mapping and the data movement.

Top module: `clock_victim_select`

## Requirements
- R1: After synchronous reset, all referenced bits are 0, the hand is at frame 0, and `busy`, `done` and `victim` are 0. The first request after reset returns frame 0 one cycle after it is sampled, and later requests confirm that no bit survived reset.
- R2: An access strobe with `acc_valid`=1 and `acc_frame` < `N_FRAMES` sets that frame's referenced bit. An access whose index is `N_FRAMES` or above is ignored.
- R3: The sweep begins at the hand and examines frames in increasing index order, wrapping from `N_FRAMES`-1 to 0. The victim is the first examined frame whose bit is 0.
- R4: Each frame the sweep passes with its bit set has that bit cleared, and the frame is not chosen in that sweep.
- R5: When a victim is chosen, the hand moves to the victim index plus one, modulo `N_FRAMES`.
- R6: If every bit is 1 when the sweep starts, all bits are cleared and the starting frame is returned. This takes `N_FRAMES`+1 cycles, which is the worst case.
- R7: If an access and a sweep clear hit the same frame in the same cycle, the access wins and the bit stays 1.
- R8: `busy` is 1 from the cycle after an accepted request until the victim is reported. A request made while `busy` is 1 is ignored and is not queued. `done` is a one-cycle pulse that is never high together with `busy`, and `victim` holds its value until the next `done`.
- R9: `done` rises k+1 clock edges after the edge that samples the request, where k is the number of set bits the sweep passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_frame | input | FRAME_W | Index of the frame accessed |
| victim_req | input | 1 | Request a victim frame |
| busy | output | 1 | Sweep in progress; requests ignored |
| done | output | 1 | One-cycle pulse: `victim` is valid |
| victim | output | FRAME_W | Index of the chosen victim frame |

## Verification
The bench uses a non-power-of-two frame count, so the sweep must wrap at `N_FRAMES`-1. A design that wrapped on the counter's width would visit frames that do not exist and return a wrong index or a wrong latency.

The bench also covers several failure modes:
- An all-ones sweep: a design that stopped after one lap would return a frame with a set bit, or return it too early.
- A collision where an access lands on the frame being cleared: a clear-priority design would lose that bit, which surfaces as a different victim in the next sweep.
- Requests held during a sweep: a design that queued them would start a second sweep.
- Stale bits across reset and across repeated sweeps: these would shift the victim order.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

    typedef enum logic [0:0] {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_state_e;

    // Longest sweep in cycles: one full lap clearing, then the start frame again.
    function automatic int unsigned worst_sweep(input int unsigned frames);
        return frames + 1;
    endfunction

endpackage

// File: rtl/clock_refbit_array.sv
module clock_refbit_array #(
    parameter int unsigned N_FRAMES = 6,
    parameter int unsigned FRAME_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [FRAME_W-1:0]  set_idx,
    input  logic                clr_en,
    input  logic [FRAME_W-1:0]  clr_idx,
    output logic [N_FRAMES-1:0] ref_bits
);

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_bit
        localparam logic [FRAME_W-1:0] MY_IDX = FRAME_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                ref_bits[g] <= 1'b0;
            end else if (set_en && set_idx == MY_IDX) begin
                ref_bits[g] <= 1'b1;
            end else if (clr_en && clr_idx == MY_IDX) begin
                ref_bits[g] <= 1'b0;
            end
        end
    end

    // R7
    access_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ref_bits[$past(set_idx)]);

    // R4
    sweep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !ref_bits[$past(clr_idx)]);

endmodule

// File: rtl/clock_hand_sweep.sv
module clock_hand_sweep
    import clock_repl_pkg::*;
#(
    parameter int unsigned N_FRAMES = 6,
    parameter int unsigned FRAME_W  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [N_FRAMES-1:0] ref_bits,
    output logic                clr_en,
    output logic [FRAME_W-1:0]  clr_idx,
    output logic                busy,
    output logic                done,
    output logic [FRAME_W-1:0]  victim
);

    localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(N_FRAMES - 1);
    localparam int unsigned        CNT_W    = FRAME_W + 1;
    localparam logic [CNT_W-1:0]   CNT_MAX  = CNT_W'(worst_sweep(N_FRAMES));

    sweep_state_e             state;
    logic [FRAME_W-1:0]       hand;
    logic [FRAME_W-1:0]       hand_next;
    logic                     cur_set;

    always_comb begin
        hand_next = (hand == LAST_IDX) ? '0 : hand + 1'b1;
        cur_set   = ref_bits[hand];
        clr_en    = (state == SWEEP_RUN) && cur_set;
        clr_idx   = hand;
        busy      = (state == SWEEP_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SWEEP_IDLE;
            hand   <= '0;
            done   <= 1'b0;
            victim <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SWEEP_IDLE: begin
                    if (req) state <= SWEEP_RUN;
                end
                SWEEP_RUN: begin
                    hand <= hand_next;
                    if (!cur_set) begin
                        victim <= hand;
                        done   <= 1'b1;
                        state  <= SWEEP_IDLE;
                    end
                end
                default: state <= SWEEP_IDLE;
            endcase
        end
    end

    // Cycle counter for the latency bound check.
    logic [CNT_W-1:0] sweep_cnt;
    always_ff @(posedge clk) begin
        if (rst || state == SWEEP_IDLE) sweep_cnt <= '0;
        else                            sweep_cnt <= sweep_cnt + 1'b1;
    end

    // R6
    sweep_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SWEEP_RUN) |-> (sweep_cnt < CNT_MAX));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R3
    victim_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(rst)) |-> (($past(ref_bits) >> victim) & N_FRAMES'(1)) == '0);

endmodule

// File: rtl/clock_victim_select.sv
module clock_victim_select #(
    parameter int unsigned N_FRAMES = 6,
    localparam int unsigned FRAME_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic [FRAME_W-1:0] acc_frame,
    input  logic               victim_req,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] victim
);

    logic                acc_ok;
    logic [N_FRAMES-1:0] ref_bits;
    logic                clr_en;
    logic [FRAME_W-1:0]  clr_idx;

    assign acc_ok = acc_valid && ({1'b0, acc_frame} < (FRAME_W + 1)'(N_FRAMES));

    clock_refbit_array #(.N_FRAMES(N_FRAMES), .FRAME_W(FRAME_W)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .set_en   (acc_ok),
        .set_idx  (acc_frame),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .ref_bits (ref_bits)
    );

    clock_hand_sweep #(.N_FRAMES(N_FRAMES), .FRAME_W(FRAME_W)) u_sweep (
        .clk      (clk),
        .rst      (rst),
        .req      (victim_req),
        .ref_bits (ref_bits),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .busy     (busy),
        .done     (done),
        .victim   (victim)
    );

    // R2
    range_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && {1'b0, acc_frame} >= (FRAME_W + 1)'(N_FRAMES)) |=>
            $stable(ref_bits) || $past(clr_en));

endmodule

// File: tb/clock_victim_select_test.sv
module clock_victim_select_test;

    localparam int N = 6;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         acc_valid = 1'b0;
    logic [W-1:0] acc_frame = '0;
    logic         victim_req = 1'b0;
    logic         busy, done;
    logic [W-1:0] victim;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    clock_victim_select #(.N_FRAMES(N)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_frame(acc_frame),
        .victim_req(victim_req), .busy(busy), .done(done), .victim(victim)
    );

    // {access mask[5:0], expected victim[2:0], expected latency[3:0]}
    localparam logic [12:0] VEC [8] = '{
        {6'b000000, 3'd0, 4'd1},   // R1 R9: empty, hand 0
        {6'b000110, 3'd3, 4'd3},   // R4: skip 1,2
        {6'b110000, 3'd0, 4'd3},   // R3: wrap past 5
        {6'b111111, 3'd1, 4'd7},   // R6: all set
        {6'b000000, 3'd2, 4'd1},   // R5: hand after victim
        {6'b001011, 3'd4, 4'd2},   // R9: one pass
        {6'b000000, 3'd5, 4'd1},   // R3
        {6'b000000, 3'd2, 4'd3}    // R4: bits 0,1 kept from before
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic touch(input int f);
        acc_valid = 1'b1;
        acc_frame = W'(f);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wait_done(output int cnt);
        cnt = 0;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic ask(input int exp_v, input int exp_lat, input string tag);
        int cnt;
        victim_req = 1'b1;
        @(negedge clk);
        victim_req = 1'b0;
        wait_done(cnt);
        chk(done == 1'b1 && int'(victim) == exp_v, tag, int'(victim), exp_v);
        chk(cnt == exp_lat, {tag, " latency"}, cnt, exp_lat);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cnt;
        repeat (2) @(negedge clk);
        // R1 reset values
        chk(busy == 0 && done == 0 && victim == 0, "R1 reset outputs", {busy, done, victim}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            for (int f = 0; f < N; f++)
                if (VEC[i][7+f]) touch(f);
            ask(int'(VEC[i][6:4]), int'(VEC[i][3:0]), $sformatf("R3 vector %0d", i));
        end

        // R2: out-of-range indices ignored; hand at 3, all bits clear
        touch(6);
        touch(7);
        ask(3, 1, "R2 out-of-range ignored");

        // R7: access collides with the clear of frame 5; hand at 4
        touch(4);
        touch(5);
        victim_req = 1'b1;
        @(negedge clk);
        victim_req = 1'b0;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_frame = 3'd5;
        @(negedge clk);
        acc_valid = 1'b0;
        wait_done(cnt);
        chk(victim == 0, "R7 collision sweep victim", int'(victim), 0);
        touch(1); touch(2); touch(3); touch(4);
        ask(0, 6, "R7 bit 5 kept by access");

        // R8: busy, ignored requests; hand at 1
        for (int f = 0; f < N; f++) touch(f);
        victim_req = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after request", busy, 1);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, "R8 busy during sweep", busy, 1);
        victim_req = 1'b0;
        wait_done(cnt);
        chk(victim == 1 && busy == 0, "R6 R8 all-set victim", int'(victim), 1);
        @(negedge clk);
        chk(done == 0 && busy == 0, "R8 no queued request", {done, busy}, 0);
        @(negedge clk);
        chk(busy == 0 && victim == 1, "R8 victim held", int'(victim), 1);
        ask(2, 1, "R5 hand after all-set sweep");

        // R1: mid-run reset clears hand and bits
        touch(3);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && done == 0 && victim == 0, "R1 reset again", int'(victim), 0);
        rst = 1'b0;
        @(negedge clk);
        ask(0, 1, "R1 hand reset");
        ask(1, 1, "R1 after reset 1");
        ask(2, 1, "R1 after reset 2");
        ask(3, 1, "R1 bit 3 cleared by reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule